// File: doc/BRIEF.md
# Round-Robin Interleaved Function Wrapper

This block gets pipeline throughput from a combinational function that takes longer than one clock period and cannot be split into stages. It keeps several copies of the function, called lanes. A phase counter advances on every clock edge. At each edge it stores the incoming operand in the next lane in turn. That lane then holds the operand unchanged while its copy of the function settles over several cycles.

An output mux picks the lane whose operand has had the full settling window. An output register then captures that lane's result. Seen from outside, the wrapper works like a pipeline of `LANES` stages:

- It takes a new operand on every clock.
- It returns the matching result exactly `LANES` cycles later.
- A valid bit travels with each operand, so gaps in the input stream appear as gaps at the output, at the same distance in cycles.

The wrapped function is a placeholder for a slow datapath. It squares the operand modulo 2^`DATA_W` and XORs that with the operand rotated left by 3 bits. In a real design, the paths from each lane's holding register to the output register would carry a multicycle timing exception.

Top module: `ilv_wrap`

## Requirements
- R1: While `rst_ni` is low and after it is released, `valid_o` reads 0 and `data_o` reads 0 until a valid result arrives.
- R2: For a valid operand x, the result is f(x) = (x*x mod 2^DATA_W) XOR (x rotated left by 3 bit positions), including corner operands 0, 1, all ones, and the most significant bit alone.
- R3: An operand presented with `valid_i`=1 in the cycle before clock edge k appears on `data_o` with `valid_o`=1 after edge k+LANES-1, i.e. LANES cycles after it was presented, with one new operand accepted on every clock.
- R4: `valid_o` equals `valid_i` delayed by exactly LANES cycles, for any pattern of `valid_i`.
- R5: In a cycle where `valid_o` is 0, `data_o` keeps the last valid result (0 if there has been none).
- R6: Lane rotation continues on every clock whether or not `valid_i` is high, so streams with random gaps keep the same latency and the correct result for every valid operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operand qualifier, sampled every cycle |
| data_i | input | DATA_W | Operand |
| valid_o | output | 1 | Result qualifier, valid_i delayed by LANES cycles |
| data_o | output | DATA_W | Registered result, held while valid_o is 0 |

## Verification
The assertions assume only that `valid_i` and `data_i` are at known levels and change away from the rising clock edge. They place no limit on how valid cycles and gaps are mixed, because the block has no back-pressure.

The stimulus drives inputs on the falling edge. It covers unbroken streams, alternating and randomly gapped valid patterns, and long idle runs. This exercises every possible alignment of the lane rotation against valid operands.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // left-rotate amount used by the placeholder function
  localparam int unsigned ROT_AMT = 3;
endpackage

// File: rtl/ilv_func.sv
module ilv_func
  import ilv_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] x_i,
  output logic [DATA_W-1:0] y_o
);
  logic [DATA_W-1:0] sq;
  logic [DATA_W-1:0] rot;

  assign sq  = x_i * x_i;
  assign rot = {x_i[DATA_W-1-ROT_AMT:0], x_i[DATA_W-1:DATA_W-ROT_AMT]};
  assign y_o = sq ^ rot;
endmodule

// File: rtl/ilv_ring.sv
module ilv_ring #(
  parameter int unsigned LANES = 2,
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [LANES-1:0] cap_en_o,
  output logic [IDX_W-1:0] sel_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LANES - 1);

  logic [IDX_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + IDX_W'(1);
  end

  always_comb begin
    for (int i = 0; i < LANES; i++) cap_en_o[i] = (cnt_q == IDX_W'(i));
  end

  // lane captured LANES-1 edges ago finishes settling this cycle
  assign sel_o = (cnt_q == LAST) ? '0 : cnt_q + IDX_W'(1);

  p_onehot_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(cap_en_o));

  p_sel_not_cap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_en_o[sel_o]);
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] res_o
);
  logic              vld_q;
  logic [DATA_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      hold_q <= '0;
    end else if (cap_i) begin
      vld_q  <= valid_i;
      hold_q <= data_i;
    end
  end

  ilv_func #(.DATA_W(DATA_W)) u_func (.x_i(hold_q), .y_o(res_o));

  assign valid_o = vld_q;
endmodule

// File: rtl/ilv_wrap.sv
module ilv_wrap #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned IDX_W = (LANES > 1) ? $clog2(LANES) : 1;

  logic [LANES-1:0]             cap_en;
  logic [IDX_W-1:0]             sel;
  logic [LANES-1:0]             lane_vld;
  logic [LANES-1:0][DATA_W-1:0] lane_res;
  logic                         sel_vld;
  logic [DATA_W-1:0]            sel_res;
  logic                         vld_q;
  logic [DATA_W-1:0]            dat_q;

  ilv_ring #(.LANES(LANES)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_o (cap_en),
    .sel_o    (sel)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ilv_lane #(.DATA_W(DATA_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cap_i   (cap_en[g]),
      .valid_i (valid_i),
      .data_i  (data_i),
      .valid_o (lane_vld[g]),
      .res_o   (lane_res[g])
    );
  end

  assign sel_vld = lane_vld[sel];
  assign sel_res = lane_res[sel];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= sel_vld;
      if (sel_vld) dat_q <= sel_res;
    end
  end

  assign valid_o = vld_q;
  assign data_o  = dat_q;

  // independent delay line for the valid alignment check
  logic [LANES-1:0] chk_vq;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_vq <= '0;
    else         chk_vq <= {chk_vq[LANES-2:0], valid_i};
  end

  p_valid_delay_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == chk_vq[LANES-1]);

  p_hold_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(data_o));
endmodule

// File: tb/sim_ilv_wrap.sv
module sim_ilv_wrap;
  localparam int unsigned W = 16;
  localparam int unsigned N = 2;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         valid_i = 1'b0;
  logic [W-1:0] data_i = '0;
  logic         valid_o;
  logic [W-1:0] data_o;

  int n_chk = 0;
  int n_bad = 0;
  int edge_cnt = 0;
  bit done = 1'b0;
  logic [W-1:0] last_d = '0;

  typedef struct {
    logic         v;
    logic [W-1:0] d;
    int           due;
    string        tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;

  ilv_wrap #(.DATA_W(W), .LANES(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .data_i(data_i),
    .valid_o(valid_o), .data_o(data_o)
  );

  function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
    logic [W-1:0] p;
    p = x * x;
    return p ^ ((x << 3) | (x >> (W - 3)));
  endfunction

  task automatic drive(input logic v, input logic [W-1:0] d, input string tag);
    item_t it;
    @(negedge clk);
    valid_i = v;
    data_i  = d;
    it.v = v; it.d = ref_f(d); it.due = edge_cnt + N; it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #1;
    edge_cnt++;
    while (sb.size() > 0 && sb[0].due == edge_cnt) begin
      item_t e;
      logic [W-1:0] exp_d;
      e = sb.pop_front();
      exp_d = e.v ? e.d : last_d;
      n_chk++;
      if (valid_o !== e.v || data_o !== exp_d) begin
        n_bad++;
        $display("FAIL %s (R4 valid, R5 hold): valid_o=%0b data_o=%h expected valid=%0b data=%h",
                 e.tag, valid_o, data_o, e.v, exp_d);
      end
      if (e.v) last_d = e.d;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: expected=finished actual=hung");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    // R1: quiet outputs during reset
    repeat (3) begin
      @(negedge clk);
      n_chk++;
      if (valid_o !== 1'b0 || data_o !== '0) begin
        n_bad++;
        $display("FAIL R1: valid_o=%0b data_o=%h expected valid=0 data=0", valid_o, data_o);
      end
    end
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after release stays quiet
    repeat (4) drive(1'b0, $urandom, "R1");
    // R3: unbroken stream
    repeat (64) drive(1'b1, $urandom, "R3");
    // R2: corner operands
    drive(1'b1, 16'h0000, "R2");
    drive(1'b1, 16'h0001, "R2");
    drive(1'b1, 16'hFFFF, "R2");
    drive(1'b1, 16'h8000, "R2");
    drive(1'b1, 16'h7FFF, "R2");
    drive(1'b1, 16'hAAAA, "R2");
    // R4: alternating valid
    for (int i = 0; i < 20; i++) drive(1'(i % 2), $urandom, "R4");
    // R5: isolated results with long holds
    drive(1'b1, 16'h1234, "R5");
    repeat (3) drive(1'b0, $urandom, "R5");
    drive(1'b1, 16'hBEEF, "R5");
    repeat (5) drive(1'b0, $urandom, "R5");
    // R6: random gaps
    for (int i = 0; i < 120; i++) drive(1'($urandom % 2), $urandom, "R6");
    // drain
    repeat (N + 3) drive(1'b0, $urandom, "R5");
    @(negedge clk);
    @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++;
      n_bad++;
      $display("FAIL R3: pending=%0d expected pending=0", sb.size());
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule